// File: doc/BRIEF.md
# Single-Channel DMA Address and Count Sequencer

This block runs the transfers of one DMA channel. The host loads a starting address and a transfer count. Writing them sets both the base copy and the working copy. The host then unmasks the channel. Each request from the peripheral raises a hold request toward the bus owner. Once hold is granted, the block performs one transfer cycle. In that cycle it drives the acknowledge, presents a 24-bit physical address and flags the direction. It then steps the address and counts the count down.

The count is programmed as the number of transfers minus one. The final transfer is the one where the working count wraps from zero to all ones, and that transfer raises terminal count. With auto-init set, both working values are reloaded from the base copies. Without it, the channel masks itself.

The physical address joins a page value held outside the block with the 16-bit working address. The address never carries into the page, so a run wraps inside its page. A parameter selects byte or word width. Byte width uses pages of 64 KiB. Word width uses pages of 128 KiB, shifts the address up one bit, forces bit 0 to zero and ignores page bit 0. In cascade mode the channel does no transfers of its own. It only links the request to the hold request and the hold grant to the acknowledge.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset the channel is masked, `hrq`, `dack` and `tc` are low, the working address and count are zero, and `residue` reads 1.
- R2: A programmed count of N-1 gives exactly N transfers. `tc` is high during the Nth transfer cycle only.
- R3: Each transfer lowers the working count by one, and the final one leaves it at 0xFFFF. `residue` always equals the working count plus one modulo 2^16, so 0xFFFF reads 0.
- R4: In single mode, one assertion of `dreq` yields exactly one transfer, however long `dreq` and `hlda` stay high. `dack` is high for exactly one cycle, after `hrq` has been granted by `hlda`.
- R5: With mode bit 5 clear, the working address rises by one after each transfer and wraps from 0xFFFF to 0x0000. The page field of the physical address stays the same.
- R6: With mode bit 5 set, the working address falls by one after each transfer and wraps from 0x0000 to 0xFFFF inside the page.
- R7: In the byte variant (WORD_WIDE=0), `phys_addr` equals {page[7:0], address[15:0]} during a transfer.
- R8: In the word variant (WORD_WIDE=1), `phys_addr` equals {page[7:1], address[15:0], 1'b0}, so page bit 0 has no effect.
- R9: Mode bits 3:2 set the direction. 01 raises `io_to_mem` for the transfer cycle, 10 raises `mem_to_io`, and 00 raises neither.
- R10: With mode bit 4 set, terminal count reloads the base address and base count into the working registers, and the channel stays unmasked.
- R11: With mode bit 4 clear, terminal count sets the mask. Later requests give no `hrq` until the host unmasks the channel.
- R12: Mode bits 7:6 = 11 select cascade. In cascade, `hrq` follows `dreq` and `dack` follows `hlda` in the same cycle while the channel is unmasked, and the working count does not change. Any other value of bits 7:6 behaves as single mode.
- R13: While the channel is masked, `dreq` produces no `hrq` and no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| prog_we | input | 1 | Loads base and working address and count |
| prog_addr | input | 16 | Start address, in transfer units |
| prog_count | input | 16 | Transfer count minus one |
| mode | input | 8 | 7:6 kind, 5 decrement, 4 auto-init, 3:2 direction, 1:0 ignored |
| page | input | 8 | Page value from outside the block |
| mask_set | input | 1 | Masks the channel |
| mask_clr | input | 1 | Unmasks the channel |
| dreq | input | 1 | Peripheral request |
| hlda | input | 1 | Hold granted |
| hrq | output | 1 | Hold request |
| dack | output | 1 | Channel acknowledge; marks the transfer cycle in single mode |
| tc | output | 1 | Terminal count, on the final transfer |
| io_to_mem | output | 1 | Transfer moves from I/O to memory |
| mem_to_io | output | 1 | Transfer moves from memory to I/O |
| phys_addr | output | 24 | Physical address |
| cur_addr | output | 16 | Working address |
| cur_count | output | 16 | Working count |
| residue | output | 16 | Transfers left: working count plus one |
| mask_o | output | 1 | Mask state |

## Verification
The assertions assume that `mode` stays fixed while a transfer is in flight. They also assume that `prog_we` is not pulsed during the transfer cycle. The bench changes mode or reprograms only when the channel is idle, with `dreq` and `hlda` low. Hold is granted only after `hrq` is seen. A byte instance and a word instance take the same stimulus. Runs of one to six transfers, wrap runs at both address ends and auto-init reloads are all checked against addresses computed in the bench.

// File: rtl/dma_chan_engine.sv
module dma_chan_engine #(
  parameter bit WORD_WIDE = 1'b0,
  parameter int AW = 16,
  parameter int PW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_addr,
  input  logic [AW-1:0] prog_count,
  input  logic [7:0]    mode,
  input  logic [PW-1:0] page,
  input  logic          mask_set,
  input  logic          mask_clr,
  input  logic          dreq,
  input  logic          hlda,
  output logic          hrq,
  output logic          dack,
  output logic          tc,
  output logic          io_to_mem,
  output logic          mem_to_io,
  output logic [PW+AW-1:0] phys_addr,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_count,
  output logic [AW-1:0] residue,
  output logic          mask_o
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_XFER, S_REL} state_t;

  state_t        state;
  logic [AW-1:0] base_addr, base_cnt;
  logic          mask_q;
  logic          cascade, xfer, at_tc, autoinit;
  logic          unused_bits;

  assign cascade  = (mode[7:6] == 2'b11);
  assign autoinit = mode[4];
  assign xfer     = (state == S_XFER);
  assign at_tc    = (cur_count == '0);

  assign hrq       = cascade ? (dreq & ~mask_q) : (state == S_REQ || state == S_XFER);
  assign dack      = cascade ? (hlda & ~mask_q) : xfer;
  assign tc        = xfer & at_tc;
  assign io_to_mem = xfer & (mode[3:2] == 2'b01);
  assign mem_to_io = xfer & (mode[3:2] == 2'b10);
  assign residue   = cur_count + AW'(1);
  assign mask_o    = mask_q;
  assign unused_bits = ^{mode[1:0], page};

  generate
    if (WORD_WIDE) begin : g_word
      assign phys_addr = {page[PW-1:1], cur_addr, 1'b0};
    end else begin : g_byte
      assign phys_addr = {page, cur_addr};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      mask_q    <= 1'b1;
      base_addr <= '0;
      base_cnt  <= '0;
      cur_addr  <= '0;
      cur_count <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (!cascade && dreq && !mask_q) state <= S_REQ;
        S_REQ:  if (hlda) state <= S_XFER;
        S_XFER: state <= S_REL;
        S_REL:  if (!dreq) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase

      if (prog_we) begin
        base_addr <= prog_addr;
        base_cnt  <= prog_count;
        cur_addr  <= prog_addr;
        cur_count <= prog_count;
      end else if (xfer) begin
        if (at_tc && autoinit) begin
          cur_addr  <= base_addr;
          cur_count <= base_cnt;
        end else begin
          cur_count <= cur_count - AW'(1);
          cur_addr  <= mode[5] ? cur_addr - AW'(1) : cur_addr + AW'(1);
        end
      end

      if (xfer && at_tc && !autoinit) mask_q <= 1'b1;
      else if (mask_set)              mask_q <= 1'b1;
      else if (mask_clr)              mask_q <= 1'b0;
    end
  end

  assert_single_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cascade && dack) |=> !dack);
  assert_ack_after_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cascade && $rose(dack)) |-> $past(hlda));
  assert_tc_in_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> dack);
  assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !prog_we && !(at_tc && autoinit)) |=> cur_count == $past(cur_count) - AW'(1));
  assert_addr_inc_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !prog_we && !(at_tc && autoinit) && !mode[5]) |=> cur_addr == $past(cur_addr) + AW'(1));
  assert_addr_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !prog_we && !(at_tc && autoinit) && mode[5]) |=> cur_addr == $past(cur_addr) - AW'(1));
  assert_reload_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && autoinit && !prog_we) |=> (cur_count == $past(base_cnt)) && !mask_o);
  assert_mask_on_tc_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tc && !autoinit) |=> mask_o);
  assert_cascade_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (cascade && state == S_IDLE && !prog_we) |=> cur_count == $past(cur_count));
  assert_masked_quiet_R13: assert property (@(posedge clk) disable iff (!rst_n)
    (!cascade && mask_o && state == S_IDLE) |=> !dack);

endmodule

// File: tb/dma_chan_engine_tb.sv
module dma_chan_engine_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_we = 0, mask_set = 0, mask_clr = 0, dreq = 0, hlda = 0;
  logic [15:0] prog_addr = '0, prog_count = '0;
  logic [7:0] mode = 8'h44, page = 8'h00;
  logic hrq, dack, tc, i2m, m2i, mask_o;
  logic [23:0] phys_b, phys_w;
  logic [15:0] cur_addr, cur_count, residue;
  logic w_hrq, w_dack, w_tc, w_i2m, w_m2i, w_mask;
  logic [15:0] w_addr, w_count, w_res;

  int checks = 0, fails = 0;
  bit done = 0;
  logic        last_tc, last_i2m, last_m2i;
  logic [23:0] last_pb, last_pw;

  always #5 clk = ~clk;

  dma_chan_engine #(.WORD_WIDE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr), .prog_count(prog_count),
    .mode(mode), .page(page), .mask_set(mask_set), .mask_clr(mask_clr), .dreq(dreq), .hlda(hlda),
    .hrq(hrq), .dack(dack), .tc(tc), .io_to_mem(i2m), .mem_to_io(m2i), .phys_addr(phys_b),
    .cur_addr(cur_addr), .cur_count(cur_count), .residue(residue), .mask_o(mask_o));

  dma_chan_engine #(.WORD_WIDE(1'b1)) dut_w (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_addr(prog_addr), .prog_count(prog_count),
    .mode(mode), .page(page), .mask_set(mask_set), .mask_clr(mask_clr), .dreq(dreq), .hlda(hlda),
    .hrq(w_hrq), .dack(w_dack), .tc(w_tc), .io_to_mem(w_i2m), .mem_to_io(w_m2i), .phys_addr(phys_w),
    .cur_addr(w_addr), .cur_count(w_count), .residue(w_res), .mask_o(w_mask));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic prog(input logic [15:0] a, input logic [15:0] c);
    prog_we = 1; prog_addr = a; prog_count = c;
    @(negedge clk); prog_we = 0;
  endtask

  task automatic unmask();
    mask_clr = 1; @(negedge clk); mask_clr = 0;
  endtask

  task automatic do_req(input bit expect_xfer);
    dreq = 1;
    @(negedge clk);
    if (!expect_xfer) begin
      chk("R13 no hrq while masked", hrq, 0);
      @(negedge clk);
      chk("R13 no hrq while masked", hrq, 0);
      dreq = 0; @(negedge clk);
      return;
    end
    chk("R4 hrq before ack", {hrq, dack}, 2'b10);
    hlda = 1;
    @(negedge clk);
    chk("R4 dack in transfer cycle", dack, 1);
    last_tc = tc; last_i2m = i2m; last_m2i = m2i; last_pb = phys_b; last_pw = phys_w;
    hlda = 0; dreq = 0;
    @(negedge clk);
    chk("R4 dack one cycle", dack, 0);
    @(negedge clk);
  endtask

  task automatic chk_phys(input logic [7:0] pg, input logic [15:0] a);
    chk("R7 byte physical address", last_pb, {pg, a});
    chk("R8 word physical address", last_pw, {pg[7:1], a, 1'b0});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {mask_o, hrq, dack, tc}, 4'b1000);
    chk("R1 reset registers", {cur_addr, cur_count}, 32'h0);
    chk("R1 reset residue", residue, 16'h1);
    rst_n = 1;
    @(negedge clk);

    // R13: masked channel ignores requests
    prog(16'h0100, 16'h0003);
    do_req(0);
    chk("R13 count untouched", cur_count, 16'h0003);

    // R2 R3 R7 R8 R9 R11 sweep over lengths
    for (int n = 1; n <= 6; n++) begin
      logic [15:0] a0;
      a0 = 16'h1230 + 16'(n);
      mode = 8'h44; page = 8'hA5;
      prog(a0, 16'(n - 1));
      chk("R3 residue after load", residue, 16'(n));
      unmask();
      for (int k = 0; k < n; k++) begin
        do_req(1);
        chk_phys(8'hA5, a0 + 16'(k));
        chk("R2 tc only on last", last_tc, (k == n - 1));
        chk("R9 io to mem", {last_i2m, last_m2i}, 2'b10);
      end
      chk("R3 count wraps", cur_count, 16'hFFFF);
      chk("R3 residue zero at end", residue, 16'h0);
      chk("R11 masked after tc", mask_o, 1);
      do_req(0);
    end

    // R5 increment wrap inside page
    mode = 8'h44; page = 8'h3C;
    prog(16'hFFFE, 16'h0002);
    unmask();
    for (int k = 0; k < 3; k++) begin
      do_req(1);
      chk_phys(8'h3C, 16'hFFFE + 16'(k));
      chk("R5 page unchanged", last_pb[23:16], 8'h3C);
    end

    // R6 decrement wrap, R9 mem to io
    mode = 8'h68; page = 8'h11;
    prog(16'h0001, 16'h0002);
    unmask();
    for (int k = 0; k < 3; k++) begin
      do_req(1);
      chk_phys(8'h11, 16'h0001 - 16'(k));
      chk("R6 page unchanged", last_pb[23:16], 8'h11);
      chk("R9 mem to io", {last_i2m, last_m2i}, 2'b01);
    end

    // R10 auto-init reload
    mode = 8'h54; page = 8'h02;
    prog(16'h4000, 16'h0001);
    unmask();
    for (int k = 0; k < 4; k++) begin
      do_req(1);
      chk_phys(8'h02, 16'h4000 + 16'(k % 2));
      chk("R10 tc every second", last_tc, (k % 2 == 1));
    end
    chk("R10 stays unmasked", mask_o, 0);
    chk("R10 count reloaded", cur_count, 16'h0001);

    // R4 held request gives one transfer
    mode = 8'h44;
    prog(16'h0500, 16'h0009);
    begin
      int nack;
      nack = 0;
      dreq = 1; hlda = 1;
      for (int i = 0; i < 6; i++) begin
        @(negedge clk);
        if (dack) nack++;
      end
      chk("R4 one transfer per request", nack, 1);
      dreq = 0; hlda = 0;
      repeat (2) @(negedge clk);
      chk("R4 count after held request", cur_count, 16'h0008);
    end

    // R9 direction 00 gives no strobe
    mode = 8'h40;
    do_req(1);
    chk("R9 no direction", {last_i2m, last_m2i}, 2'b00);

    // R12 cascade
    mode = 8'hC0;
    @(negedge clk);
    dreq = 1; #1;
    chk("R12 hrq follows dreq", hrq, 1);
    hlda = 1; #1;
    chk("R12 dack follows hlda", dack, 1);
    repeat (3) @(negedge clk);
    chk("R12 count unchanged", cur_count, 16'h0007);
    dreq = 0; hlda = 0; #1;
    chk("R12 released", {hrq, dack}, 2'b00);
    mask_set = 1; @(negedge clk); mask_set = 0;
    dreq = 1; hlda = 1; #1;
    chk("R13 cascade masked", {hrq, dack}, 2'b00);
    dreq = 0; hlda = 0;
    @(negedge clk);

    // R3 residue arithmetic
    mode = 8'h44;
    prog(16'h0000, 16'h1234);
    chk("R3 residue plus one", residue, 16'h1235);
    prog(16'h0000, 16'hFFFF);
    chk("R3 residue full count", residue, 16'h0000);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule